// File: doc/BRIEF.md
# Infrared Remote Carrier Generator

This block produces the modulated drive for an infrared remote control emitter, using only the system clock. Software writes one control word through a write strobe that is sampled on the clock. The word holds three things: a divider selection, a transmit-enable bit and an indicator-enable bit.

While transmit is enabled, the block drives one of two things. It either outputs a 50% square wave whose period is the selected number of clock cycles, or it holds a steady high level for carrier-less formats. Carrier start and divider changes are lined up with carrier period boundaries, so the emitter never sees a truncated pulse.

An active-low indicator output, meant for a "transmitting" lamp, mirrors the modulated output cycle for cycle when its enable bit is set. When that bit is clear, the indicator stays high.

Top module: `ir_carrier_gen`

## Requirements
- R1: While reset is asserted, `ir_out` is low and `ind_n` is high. The control word clears to all zeros.
- R2: On a clock edge with `wr_en` high, the control word takes `wr_data`. Bits [2:0] are the selection, bit 3 is transmit-enable and bit 4 is indicator-enable. With `wr_en` low, changes on `wr_data` have no effect on the outputs.
- R3: Selection codes 0, 1, 2, 3, 4 and 5 give a carrier period of 8, 16, 64, 96, 128 and 192 clock cycles.
- R4: For every dividing selection, the carrier is high for exactly half the period and low for the other half.
- R5: Selection codes 6 and 7 hold `ir_out` steady high for as long as transmit is enabled.
- R6: After a write that sets transmit-enable, `ir_out` is still low in the cycle after the write edge. It rises on the next edge and starts a full-length high half.
- R7: After a write that clears transmit-enable, `ir_out` is low from the following edge onward and stays low.
- R8: A selection written during a carrier period does not shorten that period. The new divisor applies from the next period boundary.
- R9: With indicator-enable set, `ind_n` equals the inverse of `ir_out` in every cycle.
- R10: With indicator-enable clear, `ind_n` stays high, even while the carrier runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 5 | Control word: selection [2:0], transmit-enable [3], indicator-enable [4] |
| ir_out | output | 1 | Modulated emitter drive, active high |
| ind_n | output | 1 | Transmit indicator, active low |

## Verification
The assertions cover the behaviour that can be judged one cycle at a time, on every cycle:
- the reset levels;
- the indicator tracking `ir_out`, or idling high;
- the output dropping after disable;
- the steady-high modes;
- the first cycle after enable being high;
- the active divisor being frozen inside a period.

The lengths of the high and low runs for each divisor, and the period-boundary handover after a mid-period selection change, span many cycles. Only the bench scenarios show these, by measuring run lengths at the ports.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

  localparam int SEL_W  = 3;
  localparam int CTRL_W = SEL_W + 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_D8     = 3'd0,
    SEL_D16    = 3'd1,
    SEL_D64    = 3'd2,
    SEL_D96    = 3'd3,
    SEL_D128   = 3'd4,
    SEL_D192   = 3'd5,
    SEL_STEADY = 3'd6,
    SEL_RSVD   = 3'd7
  } carrier_sel_e;

  typedef struct packed {
    logic         ind_en;
    logic         tx_en;
    carrier_sel_e sel;
  } ctrl_t;

  // Carrier period in clock cycles. Steady modes use the shortest period
  // so that a later change of selection is picked up quickly.
  function automatic int unsigned period_of(carrier_sel_e s);
    case (s)
      SEL_D8:   return 8;
      SEL_D16:  return 16;
      SEL_D64:  return 64;
      SEL_D96:  return 96;
      SEL_D128: return 128;
      SEL_D192: return 192;
      default:  return 8;
    endcase
  endfunction

  function automatic logic is_steady(carrier_sel_e s);
    return (s == SEL_STEADY) || (s == SEL_RSVD);
  endfunction

endpackage

// File: rtl/ir_ctrl_regs.sv
module ir_ctrl_regs
  import ir_carrier_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output ctrl_t             ctrl_q,
  output ctrl_t             ctrl_nxt
);

  assign ctrl_nxt = wr_en ? ctrl_t'(wr_data) : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_nxt;
  end

  // R2: the control word holds whenever no strobe is given
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/ir_div_counter.sv
module ir_div_counter
  import ir_carrier_pkg::*;
#(
  parameter int CNT_W = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  carrier_sel_e     sel_req,
  output carrier_sel_e     act_sel,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             carrier
);

  logic [CNT_W-1:0] last_c;
  logic [CNT_W-1:0] half_c;

  always_comb begin
    last_c = CNT_W'(period_of(act_sel) - 1);
    half_c = CNT_W'(period_of(act_sel) / 2);
  end

  assign wrap    = en && (cnt == last_c);
  assign carrier = is_steady(act_sel) || (cnt < half_c);

  // Idle or at a boundary: restart at zero and adopt the requested selection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_sel <= SEL_D8;
    end else if (!en || wrap) begin
      cnt     <= '0;
      act_sel <= sel_req;
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end

  // R8: the active divisor is frozen inside a running period
  p_sel_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != '0) |-> $stable(act_sel));

  // R3: the counter never runs past the selected period
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt <= last_c));

endmodule

// File: rtl/ir_out_gate.sv
module ir_out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ind_en,
  input  logic carrier,
  output logic ir_out,
  output logic ind_n
);

  logic ir_nxt;
  logic ind_nxt;

  assign ir_nxt  = en & carrier;
  assign ind_nxt = ~(ind_en & ir_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_out <= 1'b0;
      ind_n  <= 1'b1;
    end else begin
      ir_out <= ir_nxt;
      ind_n  <= ind_nxt;
    end
  end

  // R1: reset levels
  always @(negedge clk) begin
    if (!rst_n) p_reset_levels_r1: assert (!ir_out && ind_n);
  end

  // R7: disabled transmit forces the output low
  p_disable_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !ir_out);

  // R9: indicator mirrors the modulated output
  p_ind_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ind_en |=> (ind_n == !ir_out));

  // R10: indicator idles high when not enabled
  p_ind_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ind_en |=> ind_n);

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ir_carrier_pkg::*;
#(
  parameter int MAX_PERIOD = 192,
  localparam int CNT_W = $clog2(MAX_PERIOD)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic              ir_out,
  output logic              ind_n
);

  ctrl_t            ctrl_q;
  ctrl_t            ctrl_nxt;
  carrier_sel_e     act_sel;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             carrier;

  ir_ctrl_regs i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ctrl_q   (ctrl_q),
    .ctrl_nxt (ctrl_nxt)
  );

  ir_div_counter #(.CNT_W(CNT_W)) i_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl_q.tx_en),
    .sel_req (ctrl_nxt.sel),
    .act_sel (act_sel),
    .cnt     (cnt),
    .wrap    (wrap),
    .carrier (carrier)
  );

  ir_out_gate i_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl_q.tx_en),
    .ind_en  (ctrl_q.ind_en),
    .carrier (carrier),
    .ir_out  (ir_out),
    .ind_n   (ind_n)
  );

  // R5: steady modes hold the output high
  p_steady_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.tx_en && is_steady(act_sel)) |=> ir_out);

  // R6: the first enabled cycle opens a high half
  p_start_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.tx_en) |=> ir_out);

endmodule

// File: tb/test_ir_carrier_gen.sv
module test_ir_carrier_gen;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam int VEC_SEL [NVEC] = '{0, 1, 2, 3, 4, 5};
  localparam int VEC_PER [NVEC] = '{8, 16, 64, 96, 128, 192};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic       ir_out;
  logic       ind_n;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  ind_on = 1'b0;
  bit  ind_mismatch = 1'b0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_carrier_gen i_ir_carrier_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ir_out(ir_out), .ind_n(ind_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] word(input bit ind, input bit tx, input int sel);
    return {ind, tx, 3'(sel)};
  endfunction

  task automatic write(input logic [4:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic watch_ind();
    if (ind_on && (ind_n != !ir_out)) ind_mismatch = 1'b1;
  endtask

  // Counts negedges while ir_out holds lvl; ends on the first differing sample.
  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (ir_out == lvl && n < 1000) begin
      watch_ind();
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int hi, lo, hi2, lo2;
    bit ok;

    // R1: levels held during reset
    repeat (3) @(negedge clk);
    check("R1 ir_out in reset", ir_out, 0);
    check("R1 ind_n in reset", ind_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ir_out after reset", ir_out, 0);

    // Table walk: R3, R4, R6, R9 for every dividing selection
    ind_on = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      write(word(1, 0, VEC_SEL[v]));
      write(word(1, 1, VEC_SEL[v]));
      check("R6 low just after enable write", ir_out, 0);
      @(negedge clk);
      check("R6 high on next edge", ir_out, 1);
      ind_mismatch = 1'b0;
      run_len(1'b1, hi);
      run_len(1'b0, lo);
      run_len(1'b1, hi2);
      run_len(1'b0, lo2);
      check("R4 first high half", hi, VEC_PER[v] / 2);
      check("R3 first period", hi + lo, VEC_PER[v]);
      check("R4 second low half", lo2, VEC_PER[v] / 2);
      check("R3 second period", hi2 + lo2, VEC_PER[v]);
      check("R9 indicator mirrors output", int'(ind_mismatch), 0);
    end

    // R5: steady high for codes 6 and 7
    for (int s = 6; s < 8; s++) begin
      write(word(1, 0, s));
      write(word(1, 1, s));
      @(negedge clk);
      ok = 1'b1;
      for (int k = 0; k < 300; k++) begin
        if (!(ir_out == 1'b1 && ind_n == 1'b0)) ok = 1'b0;
        @(negedge clk);
      end
      check("R5 steady high", int'(ok), 1);
    end

    // R2: no strobe, data changes ignored (steady mode stays high)
    ok = 1'b1;
    for (int k = 0; k < 40; k++) begin
      wr_data = 5'(k * 7);
      @(negedge clk);
      if (ir_out != 1'b1) ok = 1'b0;
    end
    check("R2 unstrobed data ignored", int'(ok), 1);

    // R8: selection change mid-period waits for the boundary
    write(word(1, 0, 0));
    write(word(1, 1, 0));
    @(negedge clk);
    write(word(1, 1, 1));
    run_len(1'b1, hi);
    run_len(1'b0, lo);
    run_len(1'b1, hi2);
    run_len(1'b0, lo2);
    check("R8 old period low half kept", lo, 4);
    check("R8 new high half", hi2, 8);
    check("R8 new low half", lo2, 8);

    // R7: disable drops the output on the next edge and keeps it low
    write(word(1, 0, 1));
    @(negedge clk);
    check("R7 low after disable", ir_out, 0);
    ok = 1'b1;
    for (int k = 0; k < 50; k++) begin
      wr_data = 5'b01110;
      @(negedge clk);
      if (ir_out != 1'b0) ok = 1'b0;
    end
    check("R7 stays low (R2 no strobe)", int'(ok), 1);

    // R10: indicator disabled stays high while carrier toggles
    ind_on = 1'b0;
    write(word(0, 1, 0));
    ok = 1'b1;
    hi = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (ind_n != 1'b1) ok = 1'b0;
      if (ir_out) hi++;
    end
    check("R10 indicator idle high", int'(ok), 1);
    check("R10 carrier still running", hi, 20);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule